// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block holds a one-time-programmable bit array split into equal banks, each made of 32-bit rows, and gives a client three operations on it. A program request sets a single bit to one and can never clear a bit. A read request returns the whole 32-bit row that contains a given bit address. A check request inspects a four-bit marker in the top of each bank's first row and returns one validity flag per bank, optionally writing the marker into banks whose marker is still blank.

A small table of guarded bit addresses, loaded through a write port, blocks programming of those bits. Each operation answers one clock after its request with a one-cycle done or valid pulse. At reset the array is cleared, which stands for a blank device.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset every row reads as zero, the guard table holds no enabled entry, and prog_done, prog_ok, rd_valid, rd_err, rd_data, chk_done and chk_mask are all zero.
- R2: An accepted program of address A ORs a one into bit A%32 of row A/32 and leaves every other bit of the array unchanged. Programming a bit that is already one also reports success.
- R3: A program whose address equals the address of an enabled guard-table entry leaves the array unchanged and reports prog_ok=0. Once that entry is rewritten with enable 0, programming the same address succeeds.
- R4: Every program request yields prog_done=1 in the cycle after the request. prog_ok=1 there when the address is in range, not guarded and no check is requested in the same cycle.
- R5: A read of address A yields rd_valid=1 one cycle after the request, with rd_data equal to row A/32.
- R6: An address at or above NUM_BANKS*BANK_BITS (6144 by default) is out of range: a read of it returns rd_data=0 with rd_err=1, and a program of it reports prog_ok=0 and changes nothing.
- R7: A check yields chk_done=1 one cycle after the request with chk_mask bit b (bank 0 in bit 0) set exactly when bits 31:28 of bank b's first row (row b*BANK_BITS/32) equal 4'b1010.
- R8: When a check runs with auto_init=1, a bank whose bits 31:28 are 4'b0000 gets 4'b1010 written there and is reported valid. With auto_init=0 the blank marker stays zero and is reported invalid.
- R9: A marker that is nonzero and differs from 4'b1010 is left unchanged by a check, with or without auto_init, and is reported invalid.
- R10: When prog_req and chk_req are both high in a cycle, the check runs, the program reports prog_done=1 with prog_ok=0 and does not change the array.
- R11: A read and a program of the same row in the same cycle return the row contents from before that program.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req | input | 1 | Request to program one bit |
| prog_addr | input | 13 | Bit address to program |
| prog_done | output | 1 | Program answer pulse |
| prog_ok | output | 1 | Program accepted (valid with prog_done) |
| rd_req | input | 1 | Request to read a row |
| rd_addr | input | 13 | Bit address whose row is read |
| rd_valid | output | 1 | Read answer pulse |
| rd_data | output | 32 | Row contents |
| rd_err | output | 1 | Read address out of range |
| chk_req | input | 1 | Request a marker check |
| auto_init | input | 1 | Write the marker into blank banks during a check |
| chk_done | output | 1 | Check answer pulse |
| chk_mask | output | 3 | Per-bank marker valid, bank 0 in bit 0 |
| guard_we | input | 1 | Write one guard-table entry |
| guard_idx | input | 3 | Guard-table entry index |
| guard_addr | input | 13 | Guarded bit address |
| guard_en | input | 1 | Entry enable |

## Verification
The assertions watch on every cycle that each request is answered in the next cycle, that a guarded or check-colliding program never reports success, that an out-of-range read returns zero, that a blank marker becomes 4'b1010 right after an auto-init check and that a wrong marker stays put. Only the bench scenarios can show that the right bit of the right row is set, that neighbouring bits and rows are untouched, that disabling a guard entry re-opens its address, and that a read racing a program returns the older row.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;
  localparam int          ROW_W       = 32;
  localparam int          BITSEL_W    = 5;
  localparam int          MARK_LSB    = 28;
  localparam int          MARK_W      = 4;
  localparam logic [3:0]  MARK_GOOD   = 4'b1010;

  function automatic logic [ROW_W-1:0] mark_word();
    return {MARK_GOOD, {(ROW_W-MARK_W){1'b0}}};
  endfunction

  function automatic logic [MARK_W-1:0] mark_of(input logic [ROW_W-1:0] w);
    return w[MARK_LSB +: MARK_W];
  endfunction
endpackage

// File: rtl/otp_guard_table.sv
module otp_guard_table
  import otp_fuse_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 13,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_en,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit
);
  logic [ADDR_W-1:0] ent_addr_q [ENTRIES];
  logic [ENTRIES-1:0] ent_en_q;
  logic [ENTRIES-1:0] ent_match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = cfg_we && (cfg_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_addr_q[e] <= '0;
        ent_en_q[e]   <= 1'b0;
      end else if (sel) begin
        ent_addr_q[e] <= cfg_addr;
        ent_en_q[e]   <= cfg_en;
      end
    end

    assign ent_match[e] = ent_en_q[e] && (ent_addr_q[e] == look_addr);
  end

  assign hit = |ent_match;
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_fuse_pkg::*;
#(
  parameter int NUM_BANKS     = 3,
  parameter int ROWS_PER_BANK = 64,
  localparam int NUM_ROWS     = NUM_BANKS * ROWS_PER_BANK,
  localparam int RIDX_W       = $clog2(NUM_ROWS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_en,
  input  logic [RIDX_W-1:0]          set_row,
  input  logic [ROW_W-1:0]           set_mask,
  input  logic [NUM_BANKS-1:0]       init_en,
  input  logic [RIDX_W-1:0]          rd_row,
  output logic [ROW_W-1:0]           rd_word,
  output logic [NUM_BANKS*ROW_W-1:0] heads
);
  logic [ROW_W-1:0] rows_q [NUM_ROWS];

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic [ROW_W-1:0] or_in;
    logic [ROW_W-1:0] row_d;
    logic             row_we;

    if ((r % ROWS_PER_BANK) == 0) begin : g_head
      assign or_in = ((set_en && set_row == RIDX_W'(r)) ? set_mask : '0)
                   | (init_en[r / ROWS_PER_BANK] ? mark_word() : '0);
      assign heads[(r / ROWS_PER_BANK)*ROW_W +: ROW_W] = rows_q[r];
    end else begin : g_body
      assign or_in = (set_en && set_row == RIDX_W'(r)) ? set_mask : '0;
    end

    always_comb begin
      row_we = |or_in;
      row_d  = rows_q[r] | or_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rows_q[r] <= '0;
      else if (row_we) rows_q[r] <= row_d;
    end
  end

  assign rd_word = rows_q[rd_row];
endmodule

// File: rtl/otp_mark_check.sv
module otp_mark_check
  import otp_fuse_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       chk_req,
  input  logic                       auto_init,
  input  logic [NUM_BANKS*ROW_W-1:0] heads,
  output logic [NUM_BANKS-1:0]       init_en,
  output logic                       done_q,
  output logic [NUM_BANKS-1:0]       mask_q
);
  logic [NUM_BANKS-1:0] good_d;
  logic [NUM_BANKS-1:0] mask_d;
  logic                 done_d;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [MARK_W-1:0] mark;
    logic              blank;
    assign mark  = mark_of(heads[b*ROW_W +: ROW_W]);
    assign blank = (mark == '0);
    assign init_en[b] = chk_req && auto_init && blank;
    assign good_d[b]  = (mark == MARK_GOOD) || (auto_init && blank);

    p_init_pattern_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_req && auto_init && blank) |=> (mark == MARK_GOOD));

    p_wrong_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_req && !blank && mark != MARK_GOOD) |=> $stable(mark));
  end

  always_comb begin
    done_d = chk_req;
    mask_d = chk_req ? good_d : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      mask_q <= '0;
    end else begin
      done_q <= done_d;
      mask_q <= mask_d;
    end
  end

  p_chk_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> done_q);
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_BITS  = 2048,
  parameter int GUARD_N    = 8,
  parameter int ADDR_W     = 13,
  localparam int TOTAL_BITS    = NUM_BANKS * BANK_BITS,
  localparam int ROWS_PER_BANK = BANK_BITS / ROW_W,
  localparam int NUM_ROWS      = NUM_BANKS * ROWS_PER_BANK,
  localparam int RIDX_W        = $clog2(NUM_ROWS),
  localparam int GIDX_W        = (GUARD_N > 1) ? $clog2(GUARD_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] prog_addr,
  output logic              prog_done,
  output logic              prog_ok,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [ROW_W-1:0]  rd_data,
  output logic              rd_err,
  input  logic              chk_req,
  input  logic              auto_init,
  output logic              chk_done,
  output logic [NUM_BANKS-1:0] chk_mask,
  input  logic              guard_we,
  input  logic [GIDX_W-1:0] guard_idx,
  input  logic [ADDR_W-1:0] guard_addr,
  input  logic              guard_en
);
  if ((BANK_BITS % ROW_W) != 0) begin : g_bad_bank
    $error("BANK_BITS must be a multiple of the row width");
  end
  if ((1 << ADDR_W) < TOTAL_BITS) begin : g_bad_addr
    $error("ADDR_W too narrow for the array");
  end

  logic                 prog_in_range, rd_in_range;
  logic                 guard_hit;
  logic                 prog_accept;
  logic [RIDX_W-1:0]    prog_row, rd_row;
  logic [ROW_W-1:0]     prog_mask;
  logic [ROW_W-1:0]     rd_word;
  logic [NUM_BANKS*ROW_W-1:0] heads;
  logic [NUM_BANKS-1:0] init_en;

  logic                 prog_done_d, prog_ok_d, rd_valid_d, rd_err_d;
  logic [ROW_W-1:0]     rd_data_d;

  otp_guard_table #(.ENTRIES(GUARD_N), .ADDR_W(ADDR_W)) u_guard (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(guard_we), .cfg_idx(guard_idx), .cfg_addr(guard_addr), .cfg_en(guard_en),
    .look_addr(prog_addr), .hit(guard_hit)
  );

  otp_fuse_array #(.NUM_BANKS(NUM_BANKS), .ROWS_PER_BANK(ROWS_PER_BANK)) u_array (
    .clk(clk), .rst_n(rst_n),
    .set_en(prog_accept), .set_row(prog_row), .set_mask(prog_mask),
    .init_en(init_en), .rd_row(rd_row), .rd_word(rd_word), .heads(heads)
  );

  otp_mark_check #(.NUM_BANKS(NUM_BANKS)) u_mark (
    .clk(clk), .rst_n(rst_n),
    .chk_req(chk_req), .auto_init(auto_init), .heads(heads),
    .init_en(init_en), .done_q(chk_done), .mask_q(chk_mask)
  );

  // Address decode: row = addr / 32, bit = addr % 32.
  always_comb begin
    prog_in_range = ({1'b0, prog_addr} < (ADDR_W+1)'(TOTAL_BITS));
    rd_in_range   = ({1'b0, rd_addr}   < (ADDR_W+1)'(TOTAL_BITS));
    prog_row      = prog_in_range ? RIDX_W'(prog_addr >> BITSEL_W) : '0;
    rd_row        = rd_in_range   ? RIDX_W'(rd_addr   >> BITSEL_W) : '0;
    prog_mask     = ROW_W'(1) << prog_addr[BITSEL_W-1:0];
    prog_accept   = prog_req && !chk_req && prog_in_range && !guard_hit;
  end

  // Next-state of the answer registers.
  always_comb begin
    prog_done_d = prog_req;
    prog_ok_d   = prog_accept;
    rd_valid_d  = rd_req;
    rd_err_d    = rd_req && !rd_in_range;
    rd_data_d   = rd_data;
    if (rd_req) rd_data_d = rd_in_range ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_done <= 1'b0;
      prog_ok   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_err    <= 1'b0;
      rd_data   <= '0;
    end else begin
      prog_done <= prog_done_d;
      prog_ok   <= prog_ok_d;
      rd_valid  <= rd_valid_d;
      rd_err    <= rd_err_d;
      rd_data   <= rd_data_d;
    end
  end

  p_guard_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && guard_hit) |=> (prog_done && !prog_ok));

  p_prog_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> prog_done);

  p_ok_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ok |-> prog_done);

  p_rd_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  p_oor_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_valid && rd_data == '0));

  p_chk_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && chk_req) |=> (prog_done && !prog_ok && chk_done));
endmodule

// File: tb/otp_fuse_ctrl_bench.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_req = 0, rd_req = 0, chk_req = 0, auto_init = 0, guard_we = 0, guard_en = 0;
  logic [12:0] prog_addr = '0, rd_addr = '0, guard_addr = '0;
  logic [2:0]  guard_idx = '0;
  logic prog_done, prog_ok, rd_valid, rd_err, chk_done;
  logic [31:0] rd_data;
  logic [2:0]  chk_mask;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  otp_fuse_ctrl u_otp_fuse_ctrl (
    .clk(clk), .rst_n(rst_n),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_done(prog_done), .prog_ok(prog_ok),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .chk_req(chk_req), .auto_init(auto_init), .chk_done(chk_done), .chk_mask(chk_mask),
    .guard_we(guard_we), .guard_idx(guard_idx), .guard_addr(guard_addr), .guard_en(guard_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Each op: drive at negedge, captured at posedge, answer sampled at following negedge.
  task automatic do_prog(input logic [12:0] a, input logic exp_ok, input string req);
    @(negedge clk); prog_req = 1; prog_addr = a;
    @(negedge clk); prog_req = 0;
    check(req, {30'd0, prog_done, prog_ok}, {30'd0, 1'b1, exp_ok});
  endtask

  task automatic do_read(input logic [12:0] a, input logic [31:0] exp, input logic exp_err,
                         input string req);
    @(negedge clk); rd_req = 1; rd_addr = a;
    @(negedge clk); rd_req = 0;
    check(req, rd_data, exp);
    check(req, {30'd0, rd_valid, rd_err}, {30'd0, 1'b1, exp_err});
  endtask

  task automatic do_check(input logic ai, input logic [2:0] exp, input string req);
    @(negedge clk); chk_req = 1; auto_init = ai;
    @(negedge clk); chk_req = 0; auto_init = 0;
    check(req, {28'd0, chk_done, chk_mask}, {28'd0, 1'b1, exp});
  endtask

  task automatic do_guard(input logic [2:0] i, input logic [12:0] a, input logic en);
    @(negedge clk); guard_we = 1; guard_idx = i; guard_addr = a; guard_en = en;
    @(negedge clk); guard_we = 0;
  endtask

  // Vector fields: {op(1=prog,2=read), addr, exp_ok, exp_data, exp_err}
  localparam int NV = 15;
  localparam logic [48:0] VEC [NV] = '{
    {2'd1, 13'd5,    1'b1, 32'h0,        1'b0},
    {2'd1, 13'd37,   1'b1, 32'h0,        1'b0},
    {2'd2, 13'd0,    1'b0, 32'h00000020, 1'b0},
    {2'd2, 13'd37,   1'b0, 32'h00000020, 1'b0},
    {2'd1, 13'd100,  1'b0, 32'h0,        1'b0},
    {2'd2, 13'd100,  1'b0, 32'h00000000, 1'b0},
    {2'd1, 13'd31,   1'b1, 32'h0,        1'b0},
    {2'd2, 13'd3,    1'b0, 32'h80000020, 1'b0},
    {2'd1, 13'd5,    1'b1, 32'h0,        1'b0},
    {2'd2, 13'd6143, 1'b0, 32'h00000000, 1'b0},
    {2'd2, 13'd6144, 1'b0, 32'h00000000, 1'b1},
    {2'd1, 13'd6144, 1'b0, 32'h0,        1'b0},
    {2'd1, 13'd4095, 1'b0, 32'h0,        1'b0},
    {2'd1, 13'd6143, 1'b1, 32'h0,        1'b0},
    {2'd2, 13'd6143, 1'b0, 32'h80000000, 1'b0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 outs", {26'd0, prog_done, prog_ok, rd_valid, rd_err, chk_done, 1'b0},
          32'd0);
    check("R1 data", {rd_data[31:3], chk_mask}, 32'd0);
    do_read(13'd0, 32'h0, 1'b0, "R1 blank row");
    do_guard(3'd0, 13'd100, 1'b1);
    do_guard(3'd7, 13'd4095, 1'b1);

    // R2 R3 R4 R5 R6: vector walk
    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VEC[i];
      if (v[48:47] == 2'd1) do_prog(v[46:34], v[33], "R2/R3/R4/R6 vec prog");
      else do_read(v[46:34], v[32:1], v[0], "R2/R5/R6 vec read");
    end

    // R7: bank0 marker 1010, bank2 marker 0001, bank1 blank
    do_prog(13'd29, 1'b1, "R2 mark bit");
    do_prog(13'd4124, 1'b1, "R2 wrong mark");
    do_check(1'b0, 3'b001, "R7 R8 no auto");
    do_read(13'd2048, 32'h0, 1'b0, "R8 blank kept");
    do_check(1'b1, 3'b011, "R8 auto init");
    do_read(13'd2048, 32'hA0000000, 1'b0, "R8 written");
    do_read(13'd4124, 32'h10000000, 1'b0, "R9 wrong kept");
    do_check(1'b0, 3'b011, "R7 recheck");

    // R10: check wins over program
    @(negedge clk); chk_req = 1; prog_req = 1; prog_addr = 13'd2048;
    @(negedge clk); chk_req = 0; prog_req = 0;
    check("R10 prog rejected", {30'd0, prog_done, prog_ok}, 32'd2);
    check("R10 chk ran", {28'd0, chk_done, chk_mask}, {28'd0, 1'b1, 3'b011});
    do_read(13'd2048, 32'hA0000000, 1'b0, "R10 unchanged");

    // R11: read races program on same row
    @(negedge clk); prog_req = 1; prog_addr = 13'd2049; rd_req = 1; rd_addr = 13'd2049;
    @(negedge clk); prog_req = 0; rd_req = 0;
    check("R11 old row", rd_data, 32'hA0000000);
    check("R11 prog ok", {31'd0, prog_ok}, 32'd1);
    do_read(13'd2049, 32'hA0000002, 1'b0, "R11 new row");

    // R3: disable guard entry re-opens address
    do_guard(3'd0, 13'd100, 1'b0);
    do_prog(13'd100, 1'b1, "R3 unguarded");
    do_read(13'd100, 32'h00000010, 1'b0, "R3 bit set");

    // R1: reset mid-run clears array
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    do_read(13'd0, 32'h0, 1'b0, "R1 cleared");
    do_check(1'b0, 3'b000, "R1 marks cleared");
    do_prog(13'd4095, 1'b1, "R1 guard cleared");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule